// File: doc/BRIEF.md
# Five-Port Configuration Mesh Router Tile

This tile sits at one node of a two-dimensional configuration mesh. Each of its five inputs (north, south, east, west and the attached core) offers a 33-bit flit with a valid strobe. In every cycle the tile accepts at most one flit: a fixed priority picks the winner among the valid inputs, and the priority order depends on whether the mesh is loading programs and data or collecting results. Flits that lose arbitration are dropped, because the mesh is meant to be driven so that collisions do not occur. The winning flit is steered to its output directions, or to the local sink, through one register stage.

A head flit carries the routing information. The route it produces is stored in a slot that belongs to the input port it came in on. The body flits that follow on that port reuse the stored route until the next head flit arrives. Unicast packets go X first, then Y. Region-broadcast packets spread east along each row and south down column 0, and every node inside the region keeps a copy. Body flits that are delivered locally appear on the sink interface, tagged with the instruction or register class that the head flit gave.

There is no back-pressure. There is no ready signal on any port, and every output strobe lasts one cycle. The environment has to schedule injections so that a single input is valid per cycle wherever losing a flit matters.

Top module: `mesh_router_tile`

## Requirements
- R1: After reset, and in every cycle until the first accepted flit, all four output valids and `sink_valid` are low. Reset also clears every per-port route slot.
- R2: Flit layout. Bits [32:31] = 00 marks a unicast head and 01 marks a region-broadcast head. Bit 32 = 1 marks a body flit whose payload is bits [31:0]. In a head flit, bits [6:0] hold the destination X (the X max for a broadcast), bits [13:7] hold the destination Y (the Y max), and bit 30 = 1 marks the packet as instructions (0 = register data).
- R3: In loading mode (`collect_mode` = 0), the priority among valid inputs is west, then north, east, south and local. Only the winner is forwarded.
- R4: In collection mode (`collect_mode` = 1), the priority is local, then east, south, west and north. Only the winner is forwarded.
- R5: A unicast head goes east if dest X > node X and west if dest X < node X. Otherwise it goes south if dest Y > node Y and north if dest Y < node Y. Otherwise its route is local and it reaches no output.
- R6: A broadcast head is forwarded east when node X < X max and node Y <= Y max. It is forwarded south when node X = 0 and node Y < Y max. It is never sent west or north. Its route includes local when node X <= X max and node Y <= Y max.
- R7: A body flit takes the route stored by the last head flit accepted on the same input port. A body flit on a port that has had no head since reset is discarded.
- R8: A body flit whose stored route includes local appears on `sink_valid`/`sink_data` with its payload. `sink_is_instr` equals bit 30 of the head flit that set up the route.
- R9: Outputs change one clock after the flit is accepted, and the flit appears unchanged on every output in its route. An output valid is low in any cycle in which nothing was routed to it.
- R10: Head flits never reach the local sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| collect_mode | input | 1 | 0 = loading priority, 1 = result-collection priority |
| node_x | input | 7 | Column of this tile |
| node_y | input | 7 | Row of this tile |
| in_n_data | input | 33 | Flit from the north neighbour |
| in_n_valid | input | 1 | North flit present |
| in_s_data | input | 33 | Flit from the south neighbour |
| in_s_valid | input | 1 | South flit present |
| in_e_data | input | 33 | Flit from the east neighbour |
| in_e_valid | input | 1 | East flit present |
| in_w_data | input | 33 | Flit from the west neighbour |
| in_w_valid | input | 1 | West flit present |
| in_l_data | input | 33 | Flit injected by the local core |
| in_l_valid | input | 1 | Local flit present |
| out_n_data | output | 33 | Flit toward north |
| out_n_valid | output | 1 | North output strobe |
| out_s_data | output | 33 | Flit toward south |
| out_s_valid | output | 1 | South output strobe |
| out_e_data | output | 33 | Flit toward east |
| out_e_valid | output | 1 | East output strobe |
| out_w_data | output | 33 | Flit toward west |
| out_w_valid | output | 1 | West output strobe |
| sink_valid | output | 1 | Local payload strobe |
| sink_is_instr | output | 1 | Payload class: 1 = instruction, 0 = register |
| sink_data | output | 32 | Local payload |

## Verification
The bench drives all five inputs at once and then withdraws the current winner step by step, in both modes. A swapped priority table forwards the wrong flit to the wrong side. Body flits are checked after an unrelated head has arrived on another port. A single shared route register instead of per-port slots would steer them wrongly. The bench also sends a body flit on a port whose slot was just cleared by reset, which a design without slot reset would forward. Broadcast heads are sent both inside and outside the region, and at the region's edge column. An off-by-one comparison then produces an extra or a missing east copy or local copy.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int NPORT = 5;
  // port and direction indices; a route mask uses the same positions
  localparam int P_N = 0;
  localparam int P_S = 1;
  localparam int P_E = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;
  localparam int NDIR = 4;

  typedef logic [NPORT-1:0] pmask_t;

  typedef enum logic [1:0] {
    KIND_UNI   = 2'b00,
    KIND_BCAST = 2'b01
  } head_kind_e;

  // port that sits at priority rank r (0 = highest)
  function automatic logic [2:0] rank_port(input logic collect, input int r);
    logic [2:0] p;
    if (!collect) begin
      case (r)
        0: p = 3'(P_W);
        1: p = 3'(P_N);
        2: p = 3'(P_E);
        3: p = 3'(P_S);
        default: p = 3'(P_L);
      endcase
    end else begin
      case (r)
        0: p = 3'(P_L);
        1: p = 3'(P_E);
        2: p = 3'(P_S);
        3: p = 3'(P_W);
        default: p = 3'(P_N);
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/mrt_arbiter.sv
module mrt_arbiter
  import mrt_pkg::*;
(
  input  pmask_t req_i,
  input  logic   collect_i,
  output pmask_t grant_o
);
  logic       found;
  logic [2:0] idx;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    idx     = '0;
    for (int r = 0; r < NPORT; r++) begin
      idx = rank_port(collect_i, r);
      if (!found && req_i[idx]) begin
        grant_o[idx] = 1'b1;
        found        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrt_route.sv
module mrt_route
  import mrt_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [1:0]    kind_i,
  input  logic [CW-1:0] dest_x_i,
  input  logic [CW-1:0] dest_y_i,
  input  logic [CW-1:0] node_x,
  input  logic [CW-1:0] node_y,
  output pmask_t        dir_o
);
  logic in_rows;

  always_comb begin
    dir_o   = '0;
    in_rows = (node_y <= dest_y_i);
    if (kind_i == KIND_UNI) begin
      if (dest_x_i > node_x)      dir_o[P_E] = 1'b1;
      else if (dest_x_i < node_x) dir_o[P_W] = 1'b1;
      else if (dest_y_i > node_y) dir_o[P_S] = 1'b1;
      else if (dest_y_i < node_y) dir_o[P_N] = 1'b1;
      else                        dir_o[P_L] = 1'b1;
    end else if (kind_i == KIND_BCAST) begin
      dir_o[P_L] = (node_x <= dest_x_i) && in_rows;
      dir_o[P_E] = (node_x <  dest_x_i) && in_rows;
      dir_o[P_S] = (node_x == '0) && (node_y < dest_y_i);
    end
  end
endmodule

// File: rtl/mrt_slot.sv
module mrt_slot
  import mrt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  pmask_t dir_i,
  input  logic   cls_i,
  output pmask_t dir_o,
  output logic   cls_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
      cls_o <= 1'b0;
    end else if (load_i) begin
      dir_o <= dir_i;
      cls_o <= cls_i;
    end
  end
endmodule

// File: rtl/mesh_router_tile.sv
module mesh_router_tile
  import mrt_pkg::*;
#(
  parameter int CW     = 7,
  parameter int FLIT_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              collect_mode,
  input  logic [CW-1:0]     node_x,
  input  logic [CW-1:0]     node_y,
  input  logic [FLIT_W-1:0] in_n_data,
  input  logic              in_n_valid,
  input  logic [FLIT_W-1:0] in_s_data,
  input  logic              in_s_valid,
  input  logic [FLIT_W-1:0] in_e_data,
  input  logic              in_e_valid,
  input  logic [FLIT_W-1:0] in_w_data,
  input  logic              in_w_valid,
  input  logic [FLIT_W-1:0] in_l_data,
  input  logic              in_l_valid,
  output logic [FLIT_W-1:0] out_n_data,
  output logic              out_n_valid,
  output logic [FLIT_W-1:0] out_s_data,
  output logic              out_s_valid,
  output logic [FLIT_W-1:0] out_e_data,
  output logic              out_e_valid,
  output logic [FLIT_W-1:0] out_w_data,
  output logic              out_w_valid,
  output logic              sink_valid,
  output logic              sink_is_instr,
  output logic [FLIT_W-2:0] sink_data
);
  localparam int PAY_W   = FLIT_W - 1;
  localparam int BODY_B  = FLIT_W - 1;
  localparam int CLS_BIT = FLIT_W - 3;

  logic [FLIT_W-1:0] in_data [NPORT];
  pmask_t            in_vld;
  pmask_t            grant;
  logic [FLIT_W-1:0] sel_flit;
  pmask_t            stored_dir;
  logic              stored_cls;
  pmask_t            rc_dir;
  pmask_t            eff_dir;
  logic              any_acc;
  logic              is_head;
  pmask_t            route_q [NPORT];
  logic              cls_q   [NPORT];

  logic [FLIT_W-1:0] out_data_q [NDIR];
  logic [NDIR-1:0]   out_vld_q;

  assign in_data[P_N] = in_n_data;
  assign in_data[P_S] = in_s_data;
  assign in_data[P_E] = in_e_data;
  assign in_data[P_W] = in_w_data;
  assign in_data[P_L] = in_l_data;
  assign in_vld = {in_l_valid, in_w_valid, in_e_valid, in_s_valid, in_n_valid};

  mrt_arbiter u_arb (
    .req_i    (in_vld),
    .collect_i(collect_mode),
    .grant_o  (grant)
  );

  // one-hot select of the winning flit and its port's stored route
  always_comb begin
    sel_flit   = '0;
    stored_dir = '0;
    stored_cls = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (grant[p]) begin
        sel_flit   = sel_flit | in_data[p];
        stored_dir = stored_dir | route_q[p];
        stored_cls = stored_cls | cls_q[p];
      end
    end
  end

  assign any_acc = |grant;
  assign is_head = !sel_flit[BODY_B];

  mrt_route #(.CW(CW)) u_rc (
    .kind_i  (sel_flit[FLIT_W-1:FLIT_W-2]),
    .dest_x_i(sel_flit[CW-1:0]),
    .dest_y_i(sel_flit[2*CW-1:CW]),
    .node_x  (node_x),
    .node_y  (node_y),
    .dir_o   (rc_dir)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    mrt_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(grant[p] && is_head),
      .dir_i (rc_dir),
      .cls_i (sel_flit[CLS_BIT]),
      .dir_o (route_q[p]),
      .cls_o (cls_q[p])
    );
  end

  assign eff_dir = is_head ? rc_dir : stored_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q     <= '0;
      sink_valid    <= 1'b0;
      sink_is_instr <= 1'b0;
      sink_data     <= '0;
      for (int d = 0; d < NDIR; d++) out_data_q[d] <= '0;
    end else begin
      for (int d = 0; d < NDIR; d++) begin
        out_vld_q[d] <= any_acc && eff_dir[d];
        if (any_acc && eff_dir[d]) out_data_q[d] <= sel_flit;
      end
      sink_valid <= any_acc && !is_head && eff_dir[P_L];
      if (any_acc && !is_head && eff_dir[P_L]) begin
        sink_data     <= sel_flit[PAY_W-1:0];
        sink_is_instr <= stored_cls;
      end
    end
  end

  assign out_n_data  = out_data_q[P_N];
  assign out_s_data  = out_data_q[P_S];
  assign out_e_data  = out_data_q[P_E];
  assign out_w_data  = out_data_q[P_W];
  assign out_n_valid = out_vld_q[P_N];
  assign out_s_valid = out_vld_q[P_S];
  assign out_e_valid = out_vld_q[P_E];
  assign out_w_valid = out_vld_q[P_W];
endmodule

// File: rtl/mrt_chk.sv
module mrt_chk #(
  parameter int CW     = 7,
  parameter int FLIT_W = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              collect_mode,
  input logic [CW-1:0]     node_x,
  input logic [CW-1:0]     node_y,
  input logic [FLIT_W-1:0] in_w_data,
  input logic              in_w_valid,
  input logic [FLIT_W-1:0] in_l_data,
  input logic              in_l_valid,
  input logic              in_n_valid,
  input logic              in_s_valid,
  input logic              in_e_valid,
  input logic [FLIT_W-1:0] out_e_data,
  input logic              out_e_valid,
  input logic [FLIT_W-1:0] out_w_data,
  input logic              out_w_valid,
  input logic              out_n_valid,
  input logic              out_s_valid,
  input logic              sink_valid
);
  logic any_in, any_out, w_uni, w_bc, l_uni, w_self;

  assign any_in  = in_n_valid | in_s_valid | in_e_valid | in_w_valid | in_l_valid;
  assign any_out = out_n_valid | out_s_valid | out_e_valid | out_w_valid;
  assign w_uni   = in_w_data[FLIT_W-1:FLIT_W-2] == 2'b00;
  assign w_bc    = in_w_data[FLIT_W-1:FLIT_W-2] == 2'b01;
  assign l_uni   = in_l_data[FLIT_W-1:FLIT_W-2] == 2'b00;
  assign w_self  = w_uni && in_w_data[CW-1:0] == node_x && in_w_data[2*CW-1:CW] == node_y;

  // R9: no output strobe without an accepted flit one cycle earlier
  assert_out_needs_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(any_in));

  // R8: local delivery also needs an input flit one cycle earlier
  assert_sink_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid |-> $past(any_in));

  // R3: in loading mode west always wins and an eastward unicast leaves east
  assert_load_west_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!collect_mode && in_w_valid && w_uni && in_w_data[CW-1:0] > node_x)
    |=> (out_e_valid && out_e_data == $past(in_w_data)));

  // R4: in collection mode local always wins; a westward unicast leaves west
  assert_collect_local_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (collect_mode && in_l_valid && l_uni && in_l_data[CW-1:0] < node_x)
    |=> (out_w_valid && out_w_data == $past(in_l_data)));

  // R5, R10: a unicast head addressed to this node reaches no output and no sink
  assert_self_head_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!collect_mode && in_w_valid && w_self) |=> (!any_out && !sink_valid));

  // R6: a broadcast head never travels west or north
  assert_bcast_no_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!collect_mode && in_w_valid && w_bc) |=> (!out_w_valid && !out_n_valid));
endmodule

bind mesh_router_tile mrt_chk #(.CW(CW), .FLIT_W(FLIT_W)) chk_i (.*);

// File: tb/mesh_router_tile_tb_top.sv
`timescale 1ns/1ps
module mesh_router_tile_tb_top;
  localparam int CW = 7;
  localparam int FW = 33;
  localparam int NV = 18;
  localparam int VW = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic collect_mode = 1'b0;
  logic [CW-1:0] node_x = 7'd2;
  logic [CW-1:0] node_y = 7'd1;
  logic [FW-1:0] d [5];
  logic [4:0]    v = '0;

  logic [FW-1:0] o_n, o_s, o_e, o_w;
  logic          ov_n, ov_s, ov_e, ov_w;
  logic          sk_v, sk_i;
  logic [FW-2:0] sk_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mesh_router_tile #(.CW(CW), .FLIT_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .collect_mode(collect_mode),
    .node_x(node_x), .node_y(node_y),
    .in_n_data(d[0]), .in_n_valid(v[0]),
    .in_s_data(d[1]), .in_s_valid(v[1]),
    .in_e_data(d[2]), .in_e_valid(v[2]),
    .in_w_data(d[3]), .in_w_valid(v[3]),
    .in_l_data(d[4]), .in_l_valid(v[4]),
    .out_n_data(o_n), .out_n_valid(ov_n),
    .out_s_data(o_s), .out_s_valid(ov_s),
    .out_e_data(o_e), .out_e_valid(ov_e),
    .out_w_data(o_w), .out_w_valid(ov_w),
    .sink_valid(sk_v), .sink_is_instr(sk_i), .sink_data(sk_d)
  );

  // {mode, port, flit, expected mask {sink,W,E,S,N}, expected class}; node (2,1)
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 3'd3, 33'h000000085, 5'b00100, 1'b0}, // R5 unicast (5,1) -> east
    {1'b0, 3'd3, 33'h1DEAD0001, 5'b00100, 1'b0}, // R7 body follows west slot
    {1'b0, 3'd0, 33'h000000202, 5'b00010, 1'b0}, // R5 unicast (2,4) -> south
    {1'b0, 3'd0, 33'h100000011, 5'b00010, 1'b0}, // R7
    {1'b0, 3'd2, 33'h000000080, 5'b01000, 1'b0}, // R5 unicast (0,1) -> west
    {1'b0, 3'd1, 33'h000000002, 5'b00001, 1'b0}, // R5 unicast (2,0) -> north
    {1'b0, 3'd3, 33'h040000082, 5'b00000, 1'b0}, // R10 head to self, instr class
    {1'b0, 3'd3, 33'h112345678, 5'b10000, 1'b1}, // R8 sink, instr
    {1'b0, 3'd3, 33'h10000ABCD, 5'b10000, 1'b1}, // R8
    {1'b0, 3'd0, 33'h080000185, 5'b00100, 1'b0}, // R6 bcast (5,3): east, no sink
    {1'b0, 3'd0, 33'h100000777, 5'b10100, 1'b0}, // R6 R8 body east + sink
    {1'b0, 3'd3, 33'h080000181, 5'b00000, 1'b0}, // R6 bcast (1,3): outside
    {1'b0, 3'd3, 33'h100000099, 5'b00000, 1'b0}, // R7 empty route
    {1'b1, 3'd4, 33'h000000080, 5'b01000, 1'b0}, // R5 collect, local -> west
    {1'b1, 3'd4, 33'h1CAFE0000, 5'b01000, 1'b0}, // R7
    {1'b1, 3'd2, 33'h080000082, 5'b00000, 1'b0}, // R6 bcast (2,1): edge, local only
    {1'b1, 3'd2, 33'h100000042, 5'b10000, 1'b0}, // R8 class register
    {1'b0, 3'd1, 33'h1000000F0, 5'b00001, 1'b0}  // R7 south slot still north
  };

  task automatic check(input logic [4:0] exp, input logic [FW-1:0] fl,
                       input logic ei, input string tag);
    logic [4:0] got;
    bit bad;
    got = {sk_v, ov_w, ov_e, ov_s, ov_n};
    bad = (got != exp);
    if (exp[0] && o_n != fl) bad = 1'b1;
    if (exp[1] && o_s != fl) bad = 1'b1;
    if (exp[2] && o_e != fl) bad = 1'b1;
    if (exp[3] && o_w != fl) bad = 1'b1;
    if (exp[4] && (sk_d != fl[FW-2:0] || sk_i != ei)) bad = 1'b1;
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: mask got %b exp %b, data N%h S%h E%h W%h sink %h/%b exp flit %h class %b",
               tag, got, exp, o_n, o_s, o_e, o_w, sk_d, sk_i, fl, ei);
    end
  endtask

  task automatic step(input logic [4:0] vm);
    v = vm;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 5; k++) d[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(5'b00000, '0, 1'b0, "R1 reset state");
    step(5'b00000);
    check(5'b00000, '0, 1'b0, "R1 idle after reset");

    // table walk (R2 field layout in use throughout)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] vc;
      int pt;
      vc = VEC[i];
      collect_mode = vc[42];
      pt = int'(vc[41:39]);
      d[pt] = vc[38:6];
      v = '0;
      v[pt] = 1'b1;
      @(negedge clk);
      check(vc[5:1], vc[38:6], vc[0], $sformatf("vector %0d R5 R6 R7 R8 R9", i));
    end
    step(5'b00000);
    check(5'b00000, '0, 1'b0, "R9 valids drop when idle");

    // loading priority: W > N > E > S > L
    collect_mode = 1'b0;
    d[3] = 33'h000000085; // east
    d[0] = 33'h000000202; // south
    d[2] = 33'h000000080; // west
    d[1] = 33'h000000002; // north
    d[4] = 33'h000000202; // south
    step(5'b11111); check(5'b00100, d[3], 1'b0, "R3 west first");
    step(5'b10111); check(5'b00010, d[0], 1'b0, "R3 north second");
    step(5'b10110); check(5'b01000, d[2], 1'b0, "R3 east third");
    step(5'b10010); check(5'b00001, d[1], 1'b0, "R3 south fourth");
    step(5'b10000); check(5'b00010, d[4], 1'b0, "R3 local last");

    // collection priority: L > E > S > W > N
    collect_mode = 1'b1;
    step(5'b11111); check(5'b00010, d[4], 1'b0, "R4 local first");
    step(5'b01111); check(5'b01000, d[2], 1'b0, "R4 east second");
    step(5'b01011); check(5'b00001, d[1], 1'b0, "R4 south third");
    step(5'b01001); check(5'b00100, d[3], 1'b0, "R4 west fourth");
    step(5'b00001); check(5'b00010, d[0], 1'b0, "R4 north last");

    // reset mid-stream clears outputs and slots
    v = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check(5'b00000, '0, 1'b0, "R1 outputs cleared in reset");
    rst_n = 1'b1;
    collect_mode = 1'b0;
    d[3] = 33'h155550000;
    step(5'b01000);
    check(5'b00000, d[3], 1'b0, "R7 orphan body dropped");
    step(5'b00000);
    check(5'b00000, '0, 1'b0, "R9 quiet after drop");
    done = 1'b1;
    finish_run();
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles exp completion", cyc);
        finish_run();
      end
    end
  end
endmodule